// File: doc/BRIEF.md
# Paged Memory Window Translator

This block turns a 16-bit processor address into a physical memory target. The 64 KB address space is cut into four 16 KB windows. Each window resolves to a flash or RAM target, a page number, and a 14-bit offset inside that page. The offset is always the low 14 address bits. The memory arrays sit outside the block and use the target, page and offset to select a byte.

Four byte-wide configuration registers live on a small port bus and set the translation. The mode register picks one of two window layouts. The two bank registers each hold a page number plus a flash/RAM flag. The RAM page register chooses what the top window shows in the normal layout. Every register reads back through the same port bus.

A parameter selects a reduced device variant. In that variant the bank fields are narrower and the RAM page register has no port. Translation is purely combinational from the stored registers, so a port write applies to the first memory access after the clock edge that captured it.

Top module: `bank_mapper`

## Requirements
- R1: After reset the layout mode is 0, the RAM page is 0, and bank A and bank B both select flash page 0. In this state all four configuration ports read back 0x00.
- R2: A write to port 0x04 stores bit 0 of the data as the layout mode and discards the other bits. The port reads back as {7'b0, mode}.
- R3: In the full variant, a write to port 0x05 stores data bits 2:0 as the RAM page. The port reads back as {5'b0, page}.
- R4: In the full variant, a write to port 0x06 configures bank A and a write to port 0x07 configures bank B. Data bit 7 set means RAM and bit 7 clear means flash. Bits 6:0 are the page. A bank port reads back in the same format.
- R5: In the reduced variant (REDUCED=1), a bank write takes bit 6 as the RAM flag (1 = RAM) and bits 4:0 as the page. A bank port reads back as {1'b0, ram, 1'b0, page[4:0]}. Port 0x05 is not decoded: it reads 0x00, and writes to it leave the RAM page at 0.
- R6: In both layouts, addresses 0x0000-0x3FFF map to flash page 0.
- R7: In layout mode 0, window 0x4000 follows bank A, window 0x8000 follows bank B, and window 0xC000 shows RAM at the stored RAM page.
- R8: In layout mode 1, windows 0x4000 and 0x8000 both use bank A's target. They show bank A's page with bit 0 cleared and with bit 0 set, respectively. Window 0xC000 follows bank B.
- R9: The offset output always equals address bits 13:0.
- R10: A port write changes the translation seen from the first cycle after the clock edge that captured it. The translation depends on no other timing.
- R11: Writes to ports other than the decoded ones change no register. Cycles without a write also change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| portAddr | input | 8 | Port number for a write or for readback |
| portWrEn | input | 1 | Write strobe for the port bus |
| portWrData | input | DATA_W | Port write data |
| portRdData | output | DATA_W | Combinational readback of the port at portAddr |
| cpuAddr | input | ADDR_W | Processor address to translate |
| memIsRam | output | 1 | Target is RAM when 1, flash when 0 |
| memPage | output | PAGE_W | Physical page number |
| memOffset | output | ADDR_W-2 | Byte offset within the page |

## Verification
The full and reduced variants receive the same stimulus side by side, so field-width and flag-position differences show up as mismatches. Directed writes come first. They reproduce the RAM-page-1 top window and the mode-1 split where one RAM bank appears as two consecutive pages. They also drive masked bits in every register, which separates a correct mask from a wider field. Random writes then go to decoded and undecoded ports, and each is followed by random addresses in all four windows and a readback of every port. This separates window-routing mistakes, inverted flags, and stray register updates.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;
  localparam logic [7:0] PORT_MODE  = 8'h04;
  localparam logic [7:0] PORT_RAMPG = 8'h05;
  localparam logic [7:0] PORT_BANKA = 8'h06;
  localparam logic [7:0] PORT_BANKB = 8'h07;

  typedef struct packed {
    logic wrMode;
    logic wrRamPage;
    logic wrBankA;
    logic wrBankB;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_MODE, RD_RAMPG, RD_BANKA, RD_BANKB
  } rdSel_t;
endpackage

// File: rtl/bank_map_ctl.sv
module bank_map_ctl
  import bank_map_pkg::*;
#(
  parameter bit REDUCED = 1'b0
) (
  input  logic [7:0]  portAddr,
  input  logic        portWrEn,
  output ctlStrobes_t strobes,
  output rdSel_t      rdSel
);
  logic hitMode, hitRam, hitA, hitB;

  assign hitMode = (portAddr == PORT_MODE);
  assign hitA    = (portAddr == PORT_BANKA);
  assign hitB    = (portAddr == PORT_BANKB);

  generate
    if (REDUCED) begin : g_noRamPort
      assign hitRam = 1'b0;
    end else begin : g_ramPort
      assign hitRam = (portAddr == PORT_RAMPG);
    end
  endgenerate

  always_comb begin
    strobes.wrMode    = portWrEn && hitMode;
    strobes.wrRamPage = portWrEn && hitRam;
    strobes.wrBankA   = portWrEn && hitA;
    strobes.wrBankB   = portWrEn && hitB;
  end

  always_comb begin
    if (hitMode)     rdSel = RD_MODE;
    else if (hitRam) rdSel = RD_RAMPG;
    else if (hitA)   rdSel = RD_BANKA;
    else if (hitB)   rdSel = RD_BANKB;
    else             rdSel = RD_NONE;
  end
endmodule

// File: rtl/bank_map_dp.sv
module bank_map_dp
  import bank_map_pkg::*;
#(
  parameter bit REDUCED    = 1'b0,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 7,
  parameter int RAM_PAGE_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  rdSel_t              rdSel,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   cpuAddr,
  output logic [DATA_W-1:0]   rdData,
  output logic                memIsRam,
  output logic [PAGE_W-1:0]   memPage,
  output logic [ADDR_W-3:0]   memOffset
);
  localparam int USED_W   = REDUCED ? PAGE_W - 2 : PAGE_W;
  localparam int FLAG_BIT = REDUCED ? PAGE_W - 1 : PAGE_W;
  localparam int OFFS_W   = ADDR_W - 2;

  typedef struct packed {
    logic              isRam;
    logic [PAGE_W-1:0] page;
  } bankCfg_t;

  logic                  modeQ;
  logic [RAM_PAGE_W-1:0] ramPageQ;
  bankCfg_t              bankAQ, bankBQ, newBank;

  always_comb begin
    newBank.isRam = wrData[FLAG_BIT];
    newBank.page  = '0;
    newBank.page[USED_W-1:0] = wrData[USED_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= 1'b0;
      ramPageQ <= '0;
      bankAQ   <= '0;
      bankBQ   <= '0;
    end else begin
      if (strobes.wrMode)    modeQ    <= wrData[0];
      if (strobes.wrRamPage) ramPageQ <= wrData[RAM_PAGE_W-1:0];
      if (strobes.wrBankA)   bankAQ   <= newBank;
      if (strobes.wrBankB)   bankBQ   <= newBank;
    end
  end

  function automatic logic [DATA_W-1:0] packBank(bankCfg_t b);
    logic [DATA_W-1:0] r;
    r = '0;
    r[FLAG_BIT] = b.isRam;
    r[USED_W-1:0] = b.page[USED_W-1:0];
    return r;
  endfunction

  always_comb begin
    rdData = '0;
    unique case (rdSel)
      RD_MODE:  rdData[0] = modeQ;
      RD_RAMPG: rdData[RAM_PAGE_W-1:0] = ramPageQ;
      RD_BANKA: rdData = packBank(bankAQ);
      RD_BANKB: rdData = packBank(bankBQ);
      default:  rdData = '0;
    endcase
  end

  always_comb begin
    memIsRam = 1'b0;
    memPage  = '0;
    unique case (cpuAddr[ADDR_W-1 -: 2])
      2'd0: begin
        memIsRam = 1'b0;
        memPage  = '0;
      end
      2'd1: begin
        memIsRam = bankAQ.isRam;
        memPage  = modeQ ? {bankAQ.page[PAGE_W-1:1], 1'b0} : bankAQ.page;
      end
      2'd2: begin
        memIsRam = modeQ ? bankAQ.isRam : bankBQ.isRam;
        memPage  = modeQ ? {bankAQ.page[PAGE_W-1:1], 1'b1} : bankBQ.page;
      end
      default: begin
        memIsRam = modeQ ? bankBQ.isRam : 1'b1;
        memPage  = modeQ ? bankBQ.page : PAGE_W'(ramPageQ);
      end
    endcase
  end

  assign memOffset = cpuAddr[OFFS_W-1:0];
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_map_pkg::*;
#(
  parameter bit REDUCED    = 1'b0,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 7,
  parameter int RAM_PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        portAddr,
  input  logic              portWrEn,
  input  logic [DATA_W-1:0] portWrData,
  output logic [DATA_W-1:0] portRdData,
  input  logic [ADDR_W-1:0] cpuAddr,
  output logic              memIsRam,
  output logic [PAGE_W-1:0] memPage,
  output logic [ADDR_W-3:0] memOffset
);
  ctlStrobes_t strobes;
  rdSel_t      rdSel;

  bank_map_ctl #(.REDUCED(REDUCED)) ctl (
    .portAddr(portAddr),
    .portWrEn(portWrEn),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  bank_map_dp #(
    .REDUCED(REDUCED), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W), .RAM_PAGE_W(RAM_PAGE_W)
  ) dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .wrData   (portWrData),
    .cpuAddr  (cpuAddr),
    .rdData   (portRdData),
    .memIsRam (memIsRam),
    .memPage  (memPage),
    .memOffset(memOffset)
  );
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter bit REDUCED    = 1'b0,
  parameter int DATA_W     = 8,
  parameter int ADDR_W     = 16,
  parameter int PAGE_W     = 7,
  parameter int RAM_PAGE_W = 3
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [7:0]            portAddr,
  input logic                  portWrEn,
  input logic [DATA_W-1:0]     portWrData,
  input logic [ADDR_W-1:0]     cpuAddr,
  input logic                  memIsRam,
  input logic [PAGE_W-1:0]     memPage,
  input logic [ADDR_W-3:0]     memOffset,
  input logic                  modeQ,
  input logic [RAM_PAGE_W-1:0] ramPageQ
);
  // R6
  win0_flash_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[ADDR_W-1 -: 2] == 2'd0) |-> (!memIsRam && memPage == '0));

  // R9
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    memOffset == cpuAddr[ADDR_W-3:0]);

  // R2
  mode_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (portWrEn && portAddr == 8'h04) |=> (modeQ == $past(portWrData[0])));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portWrEn |=> ($stable(modeQ) && $stable(ramPageQ)));

  // R7
  mode0_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!modeQ && cpuAddr[ADDR_W-1 -: 2] == 2'd3)
      |-> (memIsRam && memPage == PAGE_W'(ramPageQ)));

  // R8
  mode1_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ && cpuAddr[ADDR_W-1 -: 2] == 2'd2) |-> memPage[0]);

  // R5
  reduced_ram_chk: assert property (@(posedge clk) disable iff (!rstN)
    (REDUCED && portWrEn && portAddr == 8'h05) |=> $stable(ramPageQ));
endmodule

bind bank_mapper bank_mapper_chk #(
  .REDUCED(REDUCED), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .PAGE_W(PAGE_W), .RAM_PAGE_W(RAM_PAGE_W)
) chk (
  .clk       (clk),
  .rstN      (rstN),
  .portAddr  (portAddr),
  .portWrEn  (portWrEn),
  .portWrData(portWrData),
  .cpuAddr   (cpuAddr),
  .memIsRam  (memIsRam),
  .memPage   (memPage),
  .memOffset (memOffset),
  .modeQ     (dp.modeQ),
  .ramPageQ  (dp.ramPageQ)
);

// File: tb/bank_mapper_test.sv
module bank_mapper_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  portAddr = 8'h00;
  logic        portWrEn = 1'b0;
  logic [7:0]  portWrData = 8'h00;
  logic [15:0] cpuAddr = 16'h0000;
  logic [7:0]  rdFull, rdSmall;
  logic        ramFull, ramSmall;
  logic [6:0]  pgFull, pgSmall;
  logic [13:0] offFull, offSmall;

  int errors = 0;
  int checks = 0;

  // model state, index 0 = full variant, 1 = reduced variant
  logic       mMode [2];
  logic [2:0] mRam  [2];
  logic       mARam [2];
  logic [6:0] mAPg  [2];
  logic       mBRam [2];
  logic [6:0] mBPg  [2];

  always #2 clk = ~clk;

  bank_mapper #(.REDUCED(1'b0)) uut (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .portWrEn(portWrEn),
    .portWrData(portWrData), .portRdData(rdFull), .cpuAddr(cpuAddr),
    .memIsRam(ramFull), .memPage(pgFull), .memOffset(offFull)
  );

  bank_mapper #(.REDUCED(1'b1)) uutSmall (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .portWrEn(portWrEn),
    .portWrData(portWrData), .portRdData(rdSmall), .cpuAddr(cpuAddr),
    .memIsRam(ramSmall), .memPage(pgSmall), .memOffset(offSmall)
  );

  function automatic logic [21:0] expMap(int v, logic [15:0] a);
    logic r;
    logic [6:0] p;
    case (a[15:14])
      2'd0: begin r = 1'b0; p = 7'd0; end
      2'd1: begin r = mARam[v]; p = mMode[v] ? {mAPg[v][6:1], 1'b0} : mAPg[v]; end
      2'd2: begin
        r = mMode[v] ? mARam[v] : mBRam[v];
        p = mMode[v] ? {mAPg[v][6:1], 1'b1} : mBPg[v];
      end
      default: begin
        r = mMode[v] ? mBRam[v] : 1'b1;
        p = mMode[v] ? mBPg[v] : {4'd0, mRam[v]};
      end
    endcase
    return {r, p, a[13:0]};
  endfunction

  function automatic logic [7:0] expRd(int v, logic [7:0] pa);
    case (pa)
      8'h04: return {7'd0, mMode[v]};
      8'h05: return (v == 1) ? 8'h00 : {5'd0, mRam[v]};
      8'h06: return (v == 1) ? {1'b0, mARam[v], 1'b0, mAPg[v][4:0]} : {mARam[v], mAPg[v]};
      8'h07: return (v == 1) ? {1'b0, mBRam[v], 1'b0, mBPg[v][4:0]} : {mBRam[v], mBPg[v]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic checkVal(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (addr=%h port=%h)", req, act, exp, cpuAddr, portAddr);
    end
  endtask

  task automatic modelReset();
    for (int v = 0; v < 2; v++) begin
      mMode[v] = 1'b0; mRam[v] = 3'd0;
      mARam[v] = 1'b0; mAPg[v] = 7'd0;
      mBRam[v] = 1'b0; mBPg[v] = 7'd0;
    end
  endtask

  task automatic portWrite(logic [7:0] pa, logic [7:0] d);
    @(negedge clk);
    portAddr = pa; portWrData = d; portWrEn = 1'b1;
    @(negedge clk);
    portWrEn = 1'b0;
    for (int v = 0; v < 2; v++) begin
      case (pa)
        8'h04: mMode[v] = d[0];
        8'h05: if (v == 0) mRam[v] = d[2:0];
        8'h06: begin
          mARam[v] = (v == 1) ? d[6] : d[7];
          mAPg[v]  = (v == 1) ? {2'd0, d[4:0]} : d[6:0];
        end
        8'h07: begin
          mBRam[v] = (v == 1) ? d[6] : d[7];
          mBPg[v]  = (v == 1) ? {2'd0, d[4:0]} : d[6:0];
        end
        default: ;
      endcase
    end
  endtask

  task automatic checkAddr(string req, logic [15:0] a);
    cpuAddr = a;
    #1;
    checkVal(req, {10'd0, ramFull, pgFull, offFull}, {10'd0, expMap(0, a)});
    checkVal({req, " reduced"}, {10'd0, ramSmall, pgSmall, offSmall}, {10'd0, expMap(1, a)});
  endtask

  task automatic checkPorts(string req);
    for (int pa = 3; pa <= 8; pa++) begin
      portAddr = 8'(pa);
      #1;
      checkVal(req, {24'd0, rdFull}, {24'd0, expRd(0, 8'(pa))});
      checkVal({req, " reduced"}, {24'd0, rdSmall}, {24'd0, expRd(1, 8'(pa))});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    checkPorts("R1");
    checkAddr("R1", 16'h4000);
    checkAddr("R1", 16'hC123);

    // R4 R7 R10: bank A in RAM page 0, RAM page 1 in the top window
    portWrite(8'h06, 8'h80);
    checkAddr("R10", 16'h4000);
    portWrite(8'h05, 8'h01);
    checkAddr("R7", 16'hC000);
    checkAddr("R6", 16'h0000);
    checkAddr("R9", 16'h3FFF);

    // R3 mask of RAM page
    portWrite(8'h05, 8'hFF);
    checkPorts("R3");
    checkAddr("R3", 16'hFFFF);

    // R8 alternate layout with both banks in RAM page 0
    portWrite(8'h04, 8'h01);
    portWrite(8'h07, 8'h80);
    checkAddr("R8", 16'h4000);
    checkAddr("R8", 16'h8000);
    checkAddr("R8", 16'hC000);
    checkAddr("R6", 16'h2ABC);

    // R2 only bit 0 counts
    portWrite(8'h04, 8'hFE);
    checkPorts("R2");
    checkAddr("R2", 16'hC010);

    // R5 reduced fields: flag at bit 6, page in bits 4:0
    portWrite(8'h06, 8'h40);
    checkPorts("R5");
    portWrite(8'h07, 8'hBF);
    checkPorts("R5");
    checkAddr("R5", 16'h8001);
    checkAddr("R4", 16'h4001);

    // R11 undecoded ports
    portWrite(8'h03, 8'hFF);
    portWrite(8'h08, 8'hFF);
    checkPorts("R11");
    checkAddr("R11", 16'hC777);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] pa;
      pa = ($urandom % 4 == 0) ? 8'($urandom) : 8'(4 + $urandom % 4);
      portWrite(pa, 8'($urandom));
      for (int k = 0; k < 4; k++)
        checkAddr((mMode[0] ? "R8" : "R7"), {2'(k), 14'($urandom)});
      checkPorts((pa >= 8'h04 && pa <= 8'h07) ? "R4" : "R11");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule